// File: doc/BRIEF.md
# Scoreboard Issue and Hazard Controller

This block is the control half of an out-of-order execution engine built around a central scoreboard. It accepts at most one decoded instruction per cycle, in program order. Each instruction carries an operation class, a destination register and two source registers. The instruction is bound to a free functional unit of its class: one integer unit, `NUM_MUL` multipliers, one adder and one divider. It then passes through four phases: issue, operand read, execution and result write. Instructions read operands and retire out of order.

Two tables hold all the state. A per-unit status row records the destination, the sources, the unit expected to produce each source, and a ready flag per source. A per-register result table records which unit owes a write to each register. From these tables the block raises three hazard stalls:
- Structural and WAW hazards stall issue.
- RAW hazards stall operand read.
- WAR hazards stall the result write.

The results are signalled as one-cycle pulses per unit: operand-read grant, execution start and write grant. A register-file datapath and the arithmetic units use these pulses. The block itself moves no data.

Top module: `scoreboard_ctrl`

## Requirements
- R1: A synchronous reset empties both tables and all latency counters. In the first cycle after reset, `iss_ready` is high for every class and no grant or start pulse is raised.
- R2: Issue is in order. `iss_ready` is low while every unit of the offered class is busy, and the offered instruction, and everything behind it, waits. Class codes are: 0 integer/load, 1 multiply, 2 add/subtract, 3 divide. Unit bit order is: bit 0 integer, bits 1..NUM_MUL multipliers, then the adder, then the divider.
- R3: `iss_ready` is low while the offered destination register already has a pending writer (WAW).
- R4: A multiply goes to the lowest-numbered free multiplier.
- R5: A unit's `rd_grant` pulses only once both of its sources are ready, and no earlier than the cycle after issue (RAW).
- R6: When a unit's `wr_grant` pulses, every waiting source that names it becomes ready, and its reader may take `rd_grant` in the next cycle. An instruction issued in the producer's write cycle also sees that source as ready.
- R7: `ex_start` pulses in the cycle after `rd_grant`. The earliest `wr_grant` comes LAT cycles after `ex_start`. LAT is 1 for integer, 2 for add, 10 for multiply and 40 for divide by default.
- R8: `wr_grant` is withheld while another unit holds a ready, not-yet-read source equal to this destination (WAR).
- R9: After `wr_grant`, the unit and its destination register are free. A new instruction for that unit or that register is accepted in the next cycle.
- R10: Once a reader has taken `rd_grant`, it no longer holds back a writer. That writer may be granted in the following cycle.
- R11: In any cycle, at most one `wr_grant` is raised per destination register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_class | input | 2 | Operation class of the offered instruction |
| iss_dst | input | clog2(NUM_REGS) | Destination register |
| iss_src1 | input | clog2(NUM_REGS) | First source register |
| iss_src2 | input | clog2(NUM_REGS) | Second source register |
| iss_ready | output | 1 | The offered instruction is accepted at this edge when valid |
| rd_grant | output | NUM_MUL+3 | Per unit: operands are read this cycle |
| ex_start | output | NUM_MUL+3 | Per unit: first execution cycle |
| wr_grant | output | NUM_MUL+3 | Per unit: result is written this cycle |

## Verification
The bench targets the cycle in which a producer writes and a consumer issues. A design that misses this case leaves the consumer waiting on a producer that has already gone, and it never reads. The bench also replays a long divide that holds a WAR-blocked add for five cycles. Releasing the add early would corrupt a register the divider has not yet read, and releasing it late shows up as a slipped `wr_grant`. WAW stalls, double-multiplier allocation and mid-run reset are exercised as well. Random streams over eight registers then keep every hazard type frequent against a cycle-accurate model. That model catches off-by-one latency counters and ready flags that wake a cycle early.

// File: rtl/sb_pkg.sv
package sb_pkg;

   typedef enum logic [1:0] {
      CL_INT = 2'd0,
      CL_MUL = 2'd1,
      CL_ADD = 2'd2,
      CL_DIV = 2'd3
   } op_class_t;

   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_WAIT_RD = 2'd1,
      PH_EXEC    = 2'd2,
      PH_WAIT_WR = 2'd3
   } phase_t;

endpackage

// File: rtl/sb_unit_entry.sv
// One functional-unit status row plus its latency counter.
module sb_unit_entry
   import sb_pkg::*;
#(
   parameter int RW  = 5,
   parameter int UW  = 3,
   parameter int NFU = 5,
   parameter int LAT = 1,
   parameter int CW  = 6
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           load,
   input  logic [RW-1:0]  ld_dst,
   input  logic [RW-1:0]  ld_src1,
   input  logic [RW-1:0]  ld_src2,
   input  logic           ld_q1vld,
   input  logic [UW-1:0]  ld_q1,
   input  logic           ld_q2vld,
   input  logic [UW-1:0]  ld_q2,
   input  logic [NFU-1:0] wr_bcast,
   input  logic           wr_own,
   output logic           busy,
   output logic           wr_req,
   output logic           rd_go,
   output logic           ex_go,
   output logic [RW-1:0]  dst,
   output logic [RW-1:0]  src1,
   output logic [RW-1:0]  src2,
   output logic           rdy1,
   output logic           rdy2
);

   phase_t        phase;
   logic          q1v, q2v;
   logic [UW-1:0] q1, q2;
   logic          exec_first, exec_last;

   if (LAT < 1) begin : g_bad_lat
      $error("sb_unit_entry: LAT must be at least 1");
   end

   if (LAT > 1) begin : g_cnt
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
         if (rst)
            cnt <= '0;
         else if (rd_go)
            cnt <= CW'(LAT - 1);
         else if (phase == PH_EXEC && cnt != '0)
            cnt <= cnt - 1'b1;
      end
      assign exec_first = (cnt == CW'(LAT - 1));
      assign exec_last  = (cnt == '0);
   end else begin : g_single
      assign exec_first = 1'b1;
      assign exec_last  = 1'b1;
   end

   assign busy   = (phase != PH_IDLE);
   assign wr_req = (phase == PH_WAIT_WR);
   assign rd_go  = (phase == PH_WAIT_RD) && rdy1 && rdy2;
   assign ex_go  = (phase == PH_EXEC) && exec_first;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase <= PH_IDLE;
         dst   <= '0;
         src1  <= '0;
         src2  <= '0;
         rdy1  <= 1'b0;
         rdy2  <= 1'b0;
         q1v   <= 1'b0;
         q2v   <= 1'b0;
         q1    <= '0;
         q2    <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (load) begin
                  phase <= PH_WAIT_RD;
                  dst   <= ld_dst;
                  src1  <= ld_src1;
                  src2  <= ld_src2;
                  q1v   <= ld_q1vld;
                  q2v   <= ld_q2vld;
                  q1    <= ld_q1;
                  q2    <= ld_q2;
                  rdy1  <= !ld_q1vld;
                  rdy2  <= !ld_q2vld;
               end
            end
            PH_WAIT_RD: begin
               if (rd_go) begin
                  phase <= PH_EXEC;
                  rdy1  <= 1'b0;
                  rdy2  <= 1'b0;
                  q1v   <= 1'b0;
                  q2v   <= 1'b0;
               end else begin
                  if (q1v && wr_bcast[q1]) begin
                     rdy1 <= 1'b1;
                     q1v  <= 1'b0;
                  end
                  if (q2v && wr_bcast[q2]) begin
                     rdy2 <= 1'b1;
                     q2v  <= 1'b0;
                  end
               end
            end
            PH_EXEC: begin
               if (exec_last)
                  phase <= PH_WAIT_WR;
            end
            PH_WAIT_WR: begin
               if (wr_own)
                  phase <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R7: the start pulse follows the operand read by one cycle
   assert_start_after_read_R7: assert property (@(posedge clk) disable iff (rst)
      rd_go |=> ex_go);

   // R9: a granted write frees the unit at the following edge
   assert_free_after_write_R9: assert property (@(posedge clk) disable iff (rst)
      wr_own |=> !busy);

   // R10: after reading, this row holds no ready source that could block a writer
   assert_read_releases_R10: assert property (@(posedge clk) disable iff (rst)
      rd_go |=> (!rdy1 && !rdy2));

endmodule

// File: rtl/sb_war_arb.sv
// WAR check against pending readers and per-register write arbitration.
module sb_war_arb #(
   parameter int NFU = 5,
   parameter int RW  = 5
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [NFU-1:0] wr_req,
   input  logic [RW-1:0]  dst  [NFU],
   input  logic [RW-1:0]  src1 [NFU],
   input  logic [RW-1:0]  src2 [NFU],
   input  logic [NFU-1:0] rdy1,
   input  logic [NFU-1:0] rdy2,
   output logic [NFU-1:0] grant
);

   logic [NFU-1:0] blocked;
   logic [NFU-1:0] elig;

   always_comb begin
      for (int f = 0; f < NFU; f++) begin
         blocked[f] = 1'b0;
         for (int g = 0; g < NFU; g++) begin
            if (g != f) begin
               if ((rdy1[g] && src1[g] == dst[f]) || (rdy2[g] && src2[g] == dst[f]))
                  blocked[f] = 1'b1;
            end
         end
      end
   end

   assign elig = wr_req & ~blocked;

   always_comb begin
      for (int f = 0; f < NFU; f++) begin
         grant[f] = elig[f];
         for (int h = 0; h < f; h++) begin
            if (elig[h] && dst[h] == dst[f])
               grant[f] = 1'b0;
         end
      end
   end

   for (genvar ga = 0; ga < NFU; ga++) begin : g_pa
      for (genvar gb = ga + 1; gb < NFU; gb++) begin : g_pb
         // R11: two simultaneous writes never share a destination
         assert_one_write_per_reg_R11: assert property (@(posedge clk) disable iff (rst)
            (grant[ga] && grant[gb]) |-> (dst[ga] != dst[gb]));
      end
   end

endmodule

// File: rtl/sb_regstat.sv
// Register result status: which unit owes a write to each register.
module sb_regstat #(
   parameter int NUM_REGS = 32,
   parameter int RW       = 5,
   parameter int UW       = 3,
   parameter int NFU      = 5
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           set_en,
   input  logic [RW-1:0]  set_reg,
   input  logic [UW-1:0]  set_fu,
   input  logic [NFU-1:0] clr_en,
   input  logic [RW-1:0]  clr_reg [NFU],
   input  logic [RW-1:0]  src_reg [2],
   output logic           src_vld [2],
   output logic [UW-1:0]  src_fu  [2],
   input  logic [RW-1:0]  dst_reg,
   output logic           dst_busy
);

   logic          vld_q [NUM_REGS];
   logic [UW-1:0] fu_q  [NUM_REGS];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int r = 0; r < NUM_REGS; r++) begin
            vld_q[r] <= 1'b0;
            fu_q[r]  <= '0;
         end
      end else begin
         for (int f = 0; f < NFU; f++) begin
            if (clr_en[f])
               vld_q[clr_reg[f]] <= 1'b0;
         end
         if (set_en) begin
            vld_q[set_reg] <= 1'b1;
            fu_q[set_reg]  <= set_fu;
         end
      end
   end

   for (genvar gs = 0; gs < 2; gs++) begin : g_lk
      assign src_vld[gs] = vld_q[src_reg[gs]];
      assign src_fu[gs]  = fu_q[src_reg[gs]];
   end
   assign dst_busy = vld_q[dst_reg];

   // R3: an accepted destination is marked pending at the next cycle
   assert_dst_marked_R3: assert property (@(posedge clk) disable iff (rst)
      set_en |=> vld_q[$past(set_reg)]);

endmodule

// File: rtl/scoreboard_ctrl.sv
module scoreboard_ctrl
   import sb_pkg::*;
#(
   parameter int NUM_REGS = 32,
   parameter int NUM_MUL  = 2,
   parameter int LAT_INT  = 1,
   parameter int LAT_MUL  = 10,
   parameter int LAT_ADD  = 2,
   parameter int LAT_DIV  = 40
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        iss_valid,
   input  logic [1:0]                  iss_class,
   input  logic [$clog2(NUM_REGS)-1:0] iss_dst,
   input  logic [$clog2(NUM_REGS)-1:0] iss_src1,
   input  logic [$clog2(NUM_REGS)-1:0] iss_src2,
   output logic                        iss_ready,
   output logic [NUM_MUL+2:0]          rd_grant,
   output logic [NUM_MUL+2:0]          ex_start,
   output logic [NUM_MUL+2:0]          wr_grant
);

   localparam int NFU     = NUM_MUL + 3;
   localparam int RW      = $clog2(NUM_REGS);
   localparam int UW      = $clog2(NFU);
   localparam int U_ADD   = NUM_MUL + 1;
   localparam int LAT_M1  = (LAT_INT > LAT_MUL) ? LAT_INT : LAT_MUL;
   localparam int LAT_M2  = (LAT_ADD > LAT_DIV) ? LAT_ADD : LAT_DIV;
   localparam int LAT_MAX = (LAT_M1 > LAT_M2) ? LAT_M1 : LAT_M2;
   localparam int CW      = $clog2(LAT_MAX + 1);

   if (NUM_REGS < 2 || (1 << RW) != NUM_REGS) begin : g_bad_regs
      $error("scoreboard_ctrl: NUM_REGS must be a power of two of at least 2");
   end
   if (NUM_MUL < 1) begin : g_bad_mul
      $error("scoreboard_ctrl: NUM_MUL must be at least 1");
   end
   if (LAT_INT < 1 || LAT_MUL < 1 || LAT_ADD < 1 || LAT_DIV < 1) begin : g_bad_lat
      $error("scoreboard_ctrl: every latency must be at least 1");
   end

   op_class_t      cls;
   logic [NFU-1:0] busy, wr_req, rdy1, rdy2, cand, sel_oh, load;
   logic [RW-1:0]  u_dst [NFU];
   logic [RW-1:0]  u_s1  [NFU];
   logic [RW-1:0]  u_s2  [NFU];
   logic [RW-1:0]  lk_reg [2];
   logic           lk_vld [2];
   logic [UW-1:0]  lk_fu  [2];
   logic           dst_busy, fire;
   logic [UW-1:0]  sel_id;
   logic           q1vld, q2vld;

   assign cls = op_class_t'(iss_class);

   // ---------------- issue selection ----------------
   always_comb begin
      logic found;
      found  = 1'b0;
      sel_oh = '0;
      sel_id = '0;
      for (int i = 0; i < NFU; i++) begin
         if (cand[i] && !found) begin
            sel_oh[i] = 1'b1;
            sel_id    = UW'(i);
            found     = 1'b1;
         end
      end
   end

   assign iss_ready = (|cand) && !dst_busy;
   assign fire      = iss_valid && iss_ready;
   assign load      = fire ? sel_oh : '0;

   // producer lookup; a producer writing in this very cycle counts as done
   assign lk_reg[0] = iss_src1;
   assign lk_reg[1] = iss_src2;
   assign q1vld     = lk_vld[0] && !wr_grant[lk_fu[0]];
   assign q2vld     = lk_vld[1] && !wr_grant[lk_fu[1]];

   // ---------------- per-unit status rows ----------------
   for (genvar gu = 0; gu < NFU; gu++) begin : g_unit
      localparam op_class_t UCLS = (gu == 0)       ? CL_INT :
                                   (gu <= NUM_MUL) ? CL_MUL :
                                   (gu == U_ADD)   ? CL_ADD : CL_DIV;
      localparam int ULAT = (gu == 0)       ? LAT_INT :
                            (gu <= NUM_MUL) ? LAT_MUL :
                            (gu == U_ADD)   ? LAT_ADD : LAT_DIV;

      assign cand[gu] = (cls == UCLS) && !busy[gu];

      sb_unit_entry #(
         .RW (RW),
         .UW (UW),
         .NFU(NFU),
         .LAT(ULAT),
         .CW (CW)
      ) u_entry (
         .clk     (clk),
         .rst     (rst),
         .load    (load[gu]),
         .ld_dst  (iss_dst),
         .ld_src1 (iss_src1),
         .ld_src2 (iss_src2),
         .ld_q1vld(q1vld),
         .ld_q1   (lk_fu[0]),
         .ld_q2vld(q2vld),
         .ld_q2   (lk_fu[1]),
         .wr_bcast(wr_grant),
         .wr_own  (wr_grant[gu]),
         .busy    (busy[gu]),
         .wr_req  (wr_req[gu]),
         .rd_go   (rd_grant[gu]),
         .ex_go   (ex_start[gu]),
         .dst     (u_dst[gu]),
         .src1    (u_s1[gu]),
         .src2    (u_s2[gu]),
         .rdy1    (rdy1[gu]),
         .rdy2    (rdy2[gu])
      );
   end

   // ---------------- hazard and write arbitration ----------------
   sb_war_arb #(
      .NFU(NFU),
      .RW (RW)
   ) u_war (
      .clk   (clk),
      .rst   (rst),
      .wr_req(wr_req),
      .dst   (u_dst),
      .src1  (u_s1),
      .src2  (u_s2),
      .rdy1  (rdy1),
      .rdy2  (rdy2),
      .grant (wr_grant)
   );

   // ---------------- register result status ----------------
   sb_regstat #(
      .NUM_REGS(NUM_REGS),
      .RW      (RW),
      .UW      (UW),
      .NFU     (NFU)
   ) u_regstat (
      .clk     (clk),
      .rst     (rst),
      .set_en  (fire),
      .set_reg (iss_dst),
      .set_fu  (sel_id),
      .clr_en  (wr_grant),
      .clr_reg (u_dst),
      .src_reg (lk_reg),
      .src_vld (lk_vld),
      .src_fu  (lk_fu),
      .dst_reg (iss_dst),
      .dst_busy(dst_busy)
   );

   // R2: an accepted instruction occupies the unit it was steered to
   assert_issue_occupies_R2: assert property (@(posedge clk) disable iff (rst)
      fire |=> ((busy & $past(sel_oh)) != '0));

   // R4: at most one unit is chosen per issue
   assert_single_target_R4: assert property (@(posedge clk) disable iff (rst)
      $onehot0(load));

endmodule

// File: tb/tb_scoreboard_ctrl.sv
module tb_scoreboard_ctrl;

   localparam int NU = 5;
   localparam int NR = 32;

   logic       clk = 1'b0;
   logic       rst;
   logic       iss_valid;
   logic [1:0] iss_class;
   logic [4:0] iss_dst, iss_src1, iss_src2;
   logic       iss_ready;
   logic [4:0] rd_grant, ex_start, wr_grant;

   always #4 clk = ~clk;

   scoreboard_ctrl dut (
      .clk      (clk),
      .rst      (rst),
      .iss_valid(iss_valid),
      .iss_class(iss_class),
      .iss_dst  (iss_dst),
      .iss_src1 (iss_src1),
      .iss_src2 (iss_src2),
      .iss_ready(iss_ready),
      .rd_grant (rd_grant),
      .ex_start (ex_start),
      .wr_grant (wr_grant)
   );

   int n_run, n_fail, total_cyc, tcyc, gap_pct;
   int m_ph [NU], m_t [NU], m_dst [NU], m_s1 [NU], m_s2 [NU], m_q1 [NU], m_q2 [NU];
   bit m_r1 [NU], m_r2 [NU];
   int m_rs [NR];
   int p_cls [0:511], p_d [0:511], p_a [0:511], p_b [0:511];
   int p_n, p_idx;
   logic [4:0] h_rd [0:127], h_ex [0:127], h_wr [0:127];
   bit h_acc [0:127];

   always @(posedge clk) total_cyc++;

   function automatic int lat_of(int u);
      if (u == 0) return 1;
      if (u <= 2) return 10;
      if (u == 3) return 2;
      return 40;
   endfunction

   function automatic int ucls(int u);
      if (u == 0) return 0;
      if (u <= 2) return 1;
      if (u == 3) return 2;
      return 3;
   endfunction

   task automatic m_reset();
      for (int u = 0; u < NU; u++) begin
         m_ph[u] = 0; m_t[u] = 0; m_dst[u] = 0; m_s1[u] = 0; m_s2[u] = 0;
         m_q1[u] = -1; m_q2[u] = -1; m_r1[u] = 0; m_r2[u] = 0;
      end
      for (int r = 0; r < NR; r++) m_rs[r] = -1;
   endtask

   function automatic bit m_idle();
      for (int u = 0; u < NU; u++) if (m_ph[u] != 0) return 0;
      return 1;
   endfunction

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic add(input int c, input int d, input int a, input int b);
      p_cls[p_n] = c; p_d[p_n] = d; p_a[p_n] = a; p_b[p_n] = b;
      p_n++;
   endtask

   task automatic step();
      bit have, e_ready, fire, blk;
      logic [4:0] e_rd, e_ex, e_wr;
      int sel, q1, q2;
      @(negedge clk);
      tcyc++;
      have = (p_idx < p_n) && (($urandom % 100) >= gap_pct);
      iss_valid = have;
      if (p_idx < p_n) begin
         iss_class = 2'(p_cls[p_idx]); iss_dst = 5'(p_d[p_idx]);
         iss_src1 = 5'(p_a[p_idx]); iss_src2 = 5'(p_b[p_idx]);
      end else begin
         iss_class = 2'd0; iss_dst = 5'd0; iss_src1 = 5'd0; iss_src2 = 5'd0;
      end
      #1;
      // expected outputs from the model state
      e_ready = 0; sel = -1;
      for (int u = 0; u < NU; u++)
         if (ucls(u) == int'(iss_class) && m_ph[u] == 0) begin
            e_ready = 1;
            if (sel < 0) sel = u;
         end
      if (m_rs[iss_dst] >= 0) e_ready = 0;
      for (int u = 0; u < NU; u++) begin
         e_rd[u] = (m_ph[u] == 1) && m_r1[u] && m_r2[u];
         e_ex[u] = (m_ph[u] == 2) && (m_t[u] == 0);
         blk = 0;
         for (int g = 0; g < NU; g++)
            if (g != u && ((m_r1[g] && m_s1[g] == m_dst[u]) || (m_r2[g] && m_s2[g] == m_dst[u])))
               blk = 1;
         e_wr[u] = (m_ph[u] == 3) && !blk;
      end
      for (int u = 0; u < NU; u++)
         for (int h = 0; h < u; h++)
            if (e_wr[h] && e_wr[u] && m_dst[h] == m_dst[u]) e_wr[u] = 0;
      chk(iss_ready === e_ready, "R2 R3", "iss_ready", int'(iss_ready), int'(e_ready));
      chk(rd_grant === e_rd, "R5 R6", "rd_grant", int'(rd_grant), int'(e_rd));
      chk(ex_start === e_ex, "R7", "ex_start", int'(ex_start), int'(e_ex));
      chk(wr_grant === e_wr, "R8 R10", "wr_grant", int'(wr_grant), int'(e_wr));
      for (int u = 0; u < NU; u++)
         for (int g = u + 1; g < NU; g++)
            if (wr_grant[u] && wr_grant[g] && m_dst[u] == m_dst[g])
               chk(0, "R11", "same-register writes", m_dst[u], -1);
      if (tcyc < 128) begin
         h_rd[tcyc] = rd_grant; h_ex[tcyc] = ex_start; h_wr[tcyc] = wr_grant;
         h_acc[tcyc] = iss_valid && iss_ready;
      end
      // advance the model by one clock edge
      fire = have && e_ready;
      q1 = m_rs[iss_src1]; q2 = m_rs[iss_src2];
      if (q1 >= 0 && e_wr[q1]) q1 = -1;
      if (q2 >= 0 && e_wr[q2]) q2 = -1;
      for (int u = 0; u < NU; u++)
         if (m_ph[u] == 2) begin
            m_t[u]++;
            if (m_t[u] == lat_of(u)) m_ph[u] = 3;
         end
      for (int u = 0; u < NU; u++)
         if (e_rd[u]) begin
            m_ph[u] = 2; m_t[u] = 0; m_r1[u] = 0; m_r2[u] = 0; m_q1[u] = -1; m_q2[u] = -1;
         end
      for (int u = 0; u < NU; u++)
         if (e_wr[u]) begin
            m_ph[u] = 0; m_rs[m_dst[u]] = -1;
            for (int g = 0; g < NU; g++)
               if (m_ph[g] == 1) begin
                  if (m_q1[g] == u) begin m_r1[g] = 1; m_q1[g] = -1; end
                  if (m_q2[g] == u) begin m_r2[g] = 1; m_q2[g] = -1; end
               end
         end
      if (fire) begin
         m_ph[sel] = 1; m_dst[sel] = int'(iss_dst);
         m_s1[sel] = int'(iss_src1); m_s2[sel] = int'(iss_src2);
         m_q1[sel] = q1; m_q2[sel] = q2; m_r1[sel] = (q1 < 0); m_r2[sel] = (q2 < 0);
         m_rs[iss_dst] = sel;
         p_idx++;
      end
   endtask

   task automatic run_prog(input int gap, input int maxc);
      int c;
      gap_pct = gap; p_idx = 0; tcyc = 0; c = 0;
      for (int i = 0; i < 128; i++) begin
         h_rd[i] = '0; h_ex[i] = '0; h_wr[i] = '0; h_acc[i] = 0;
      end
      while (!(p_idx >= p_n && m_idle()) && c < maxc) begin
         step();
         c++;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; iss_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_reset();
      #1;
      chk(rd_grant == 0 && ex_start == 0 && wr_grant == 0, "R1", "pulses after reset",
          int'(rd_grant | ex_start | wr_grant), 0);
      for (int c = 0; c < 4; c++) begin
         iss_class = 2'(c); iss_dst = 5'(c); #1;
         chk(iss_ready === 1'b1, "R1", "iss_ready after reset", int'(iss_ready), 1);
      end
   endtask

   initial begin
      wait (total_cyc >= 150000);
      n_fail++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", total_cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      n_run = 0; n_fail = 0; total_cyc = 0; gap_pct = 0; p_n = 0; p_idx = 0; tcyc = 0;
      rst = 1'b1; iss_valid = 1'b0; iss_class = 2'd0;
      iss_dst = 5'd0; iss_src1 = 5'd0; iss_src2 = 5'd0;
      m_reset();
      do_reset();

      // Trace A: load/load/mul/sub/div/add sequence with RAW, WAR and structural stalls
      p_n = 0;
      add(0, 6, 20, 20); add(0, 2, 21, 21); add(1, 0, 2, 4);
      add(2, 8, 6, 2);   add(3, 10, 0, 6);  add(2, 6, 8, 2);
      run_prog(0, 200);
      chk(h_acc[1] == 1, "R2", "first issue c1", int'(h_acc[1]), 1);
      chk(!h_acc[2] && !h_acc[3] && !h_acc[4], "R2", "integer busy c2-c4", int'(h_acc[4]), 0);
      chk(h_acc[5] == 1, "R9", "integer reissue c5", int'(h_acc[5]), 1);
      chk(h_wr[4][0] == 1, "R7", "integer write c4", int'(h_wr[4][0]), 1);
      chk(h_rd[8][1] == 0 && h_rd[9][1] == 1, "R6", "mul reads c9", int'(h_rd[9][1]), 1);
      chk(h_rd[8][3] == 0, "R5", "sub waits c8", int'(h_rd[8][3]), 0);
      chk(h_ex[10][1] == 1 && h_wr[20][1] == 1, "R7", "mul start c10 write c20", int'(h_wr[20][1]), 1);
      chk(h_wr[12][3] == 1, "R7", "sub write c12", int'(h_wr[12][3]), 1);
      chk(h_acc[12] == 0 && h_acc[13] == 1, "R9", "add issues c13", int'(h_acc[13]), 1);
      for (int c = 17; c <= 21; c++)
         chk(h_wr[c][3] == 0, "R8", "add WAR hold", int'(h_wr[c][3]), 0);
      chk(h_rd[21][4] == 1, "R6", "div reads c21", int'(h_rd[21][4]), 1);
      chk(h_wr[22][3] == 1, "R10", "add writes c22", int'(h_wr[22][3]), 1);
      chk(h_ex[22][4] == 1 && h_wr[61][4] == 0 && h_wr[62][4] == 1, "R7", "div write c62",
          int'(h_wr[62][4]), 1);

      // Trace B: two multipliers, WAW stall, wake-up
      p_n = 0;
      add(1, 1, 9, 9); add(1, 2, 9, 9); add(2, 1, 9, 9); add(3, 3, 1, 1); add(0, 4, 3, 3);
      run_prog(0, 200);
      chk(h_acc[1] && h_acc[2], "R4", "both multipliers accept", int'(h_acc[2]), 1);
      chk(h_rd[2][1] == 1 && h_rd[3][2] == 1, "R4", "second mul on unit 2", int'(h_rd[3]), 4);
      chk(h_wr[13][1] == 1, "R7", "mul1 write c13", int'(h_wr[13][1]), 1);
      chk(h_acc[13] == 0, "R3", "WAW holds c13", int'(h_acc[13]), 0);
      chk(h_acc[14] == 1, "R9", "WAW released c14", int'(h_acc[14]), 1);
      chk(h_rd[18][4] == 0 && h_rd[19][4] == 1, "R6", "div wakes c19", int'(h_rd[19][4]), 1);

      // Trace C: consumer issued in its producer's write cycle
      p_n = 0;
      add(0, 5, 9, 9); add(2, 6, 5, 9); add(3, 8, 9, 9); add(1, 7, 5, 9);
      run_prog(0, 200);
      chk(h_acc[4] == 1, "R6", "mul issues during write", int'(h_acc[4]), 1);
      chk(h_rd[5][1] == 1, "R6", "forwarded ready read c5", int'(h_rd[5][1]), 1);
      chk(h_rd[5][3] == 1, "R6", "woken adder read c5", int'(h_rd[5][3]), 1);

      // Mid-run reset
      p_n = 0;
      for (int i = 0; i < 12; i++) add(i % 4, i % 6, (i + 1) % 6, (i + 3) % 6);
      run_prog(0, 15);
      do_reset();
      p_n = 0;
      run_prog(0, 0);
      for (int i = 0; i < 3; i++) step();

      // Random stream with dense hazards
      p_n = 0;
      for (int i = 0; i < 300; i++)
         add(int'($urandom % 4), int'($urandom % 8), int'($urandom % 8), int'($urandom % 8));
      run_prog(20, 40000);
      chk(p_idx == p_n && m_idle(), "R2", "random stream drained", p_idx, p_n);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule